// File: doc/BRIEF.md
# Ring Buffer Descriptor Generator

This block is the control sequencer that sits in front of a memory-to-memory DMA engine. Its job is to move words drained from a local FIFO into a ring buffer in host memory. When the block is idle and the FIFO reports words waiting, it takes a batch of up to one ring's worth of words. It then queues DMA descriptors for that batch, one at a time, over a valid/ready handshake.

Every batch begins with a status descriptor. That descriptor copies a one-word status record, holding the updated write index and the running word count, from a fixed local address to a fixed host address. Next comes the data descriptor, which writes into the ring at the current write index. If the batch would run past the last ring slot, a third descriptor carries the rest of the batch, starting at the first ring slot. The status record contents are also shown on ports, because the record's local source address reads those values.

The ring holds 254 words of 16 bytes, at host addresses 0xC800_0020 up to 0xC800_0FFF. The status record goes to host address 0xC800_0010. All lengths are whole 16-byte words.

Top module: `rb_desc_gen`

## Requirements
- R1: While reset is low, and afterwards until a batch starts, desc_valid is 0 and stat_ptr and stat_count are 0.
- R2: A fifo_level of 0 in the idle state starts no batch, produces no descriptor and leaves stat_ptr and stat_count unchanged.
- R3: The first descriptor of every batch is the status copy: src 0x0000_1000, dst 0xC800_0010, length 16 bytes.
- R4: The second descriptor has src 0x0000_2000 (the FIFO port) and dst 0xC800_0020 + 16*P, where P is the write index at batch start. Its length is 16*min(N, 254-P) bytes, where N is the batch length in words.
- R5: When N > 254-P, a third descriptor follows with src 0x0000_2000, dst 0xC800_0020, and a length of 16*(N-(254-P)) bytes. Otherwise the batch has exactly two descriptors.
- R6: The batch length N is the smaller of fifo_level and 254, so a batch never writes more than 254 words in total.
- R7: Every descriptor length is a non-zero multiple of 16 and at most 4096 bytes. No data descriptor reaches address 0xC800_1000 or above, or any address below 0xC800_0020.
- R8: While desc_valid is 1 and desc_ready is 0, desc_valid stays 1 and desc_src, desc_dst and desc_len do not change.
- R9: At batch start, stat_ptr becomes (P+N) mod 254 and stat_count grows by N. Both values are visible while the status descriptor is presented. stat_ptr always stays below 254.
- R10: A descriptor is handed over only on a clock edge where desc_valid and desc_ready are both 1. After the last descriptor of a batch, desc_valid drops for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | 9 | Number of words waiting in the local FIFO |
| desc_ready | input | 1 | DMA engine can accept a descriptor |
| desc_valid | output | 1 | A descriptor is presented |
| desc_src | output | 32 | Descriptor source address |
| desc_dst | output | 32 | Descriptor destination address |
| desc_len | output | 13 | Descriptor length in bytes |
| stat_count | output | 32 | Running count of words written (status record) |
| stat_ptr | output | 8 | Ring write index in words (status record) |

## Verification
The assertions assume nothing about desc_ready: the engine may stall any descriptor for any number of cycles. fifo_level is assumed to count words, and it is only sampled while the block is idle. The stimulus raises fifo_level for a single cycle per batch and then returns it to zero, so each request starts exactly one batch. desc_ready is either held high or toggled in a repeating pattern that stalls two cycles out of three, which exercises the hold rule on every kind of descriptor.

// File: rtl/rb_desc_pkg.sv
package rb_desc_pkg;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_STAT = 2'd1,
    K_DATA = 2'd2,
    K_WRAP = 2'd3
  } desc_kind_e;

  // Words taken for one batch: capped at the ring capacity.
  function automatic int unsigned clamp_words(int unsigned lvl, int unsigned cap);
    return (lvl > cap) ? cap : lvl;
  endfunction

  // Words that fit from index ptr up to the ring's last slot.
  function automatic int unsigned head_words(int unsigned ptr, int unsigned total,
                                             int unsigned cap);
    int unsigned room;
    room = cap - ptr;
    return (total < room) ? total : room;
  endfunction

  // Write index after total words, wrapped at cap (total <= cap).
  function automatic int unsigned next_index(int unsigned ptr, int unsigned total,
                                             int unsigned cap);
    int unsigned s;
    s = ptr + total;
    return (s >= cap) ? (s - cap) : s;
  endfunction

endpackage

// File: rtl/rb_batch_split.sv
module rb_batch_split #(
  parameter int LVL_W      = 9,
  parameter int PTR_W      = 8,
  parameter int WRD_W      = 8,
  parameter int RING_WORDS = 254
) (
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [PTR_W-1:0] cur_ptr,
  output logic [WRD_W-1:0] total,
  output logic [WRD_W-1:0] head,
  output logic [WRD_W-1:0] tail,
  output logic [PTR_W-1:0] nxt_ptr
);
  import rb_desc_pkg::*;

  always_comb begin
    total   = WRD_W'(clamp_words(32'(fifo_level), RING_WORDS));
    head    = WRD_W'(head_words(32'(cur_ptr), 32'(total), RING_WORDS));
    tail    = total - head;
    nxt_ptr = PTR_W'(next_index(32'(cur_ptr), 32'(total), RING_WORDS));
  end

endmodule

// File: rtl/rb_ring_state.sv
module rb_ring_state #(
  parameter int PTR_W = 8,
  parameter int WRD_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_batch_start,
  input  logic [WRD_W-1:0] total,
  input  logic [WRD_W-1:0] head,
  input  logic [WRD_W-1:0] tail,
  input  logic [PTR_W-1:0] nxt_ptr,
  output logic [PTR_W-1:0] cur_ptr,
  output logic [CNT_W-1:0] word_count,
  output logic [PTR_W-1:0] bat_ptr,
  output logic [WRD_W-1:0] bat_head,
  output logic [WRD_W-1:0] bat_tail
);

  // Index and count move at batch start so the status copy shows new values.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ptr    <= '0;
      word_count <= '0;
      bat_ptr    <= '0;
      bat_head   <= '0;
      bat_tail   <= '0;
    end else if (ev_batch_start) begin
      cur_ptr    <= nxt_ptr;
      word_count <= word_count + CNT_W'(total);
      bat_ptr    <= cur_ptr;
      bat_head   <= head;
      bat_tail   <= tail;
    end
  end

endmodule

// File: rtl/rb_desc_fsm.sv
module rb_desc_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    level_nz,
  input  logic                    desc_ready,
  input  logic                    has_tail,
  output rb_desc_pkg::desc_kind_e kind,
  output logic                    desc_valid,
  output logic                    ev_batch_start,
  output logic                    ev_issue
);
  import rb_desc_pkg::*;

  desc_kind_e state_q, state_d;

  assign kind           = state_q;
  assign desc_valid     = (state_q != K_IDLE);
  assign ev_issue       = desc_valid && desc_ready;
  assign ev_batch_start = (state_q == K_IDLE) && level_nz;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      K_IDLE: if (level_nz) state_d = K_STAT;
      K_STAT: if (desc_ready) state_d = K_DATA;
      K_DATA: if (desc_ready) state_d = has_tail ? K_WRAP : K_IDLE;
      K_WRAP: if (desc_ready) state_d = K_IDLE;
      default: state_d = K_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= K_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/rb_desc_fields.sv
module rb_desc_fields #(
  parameter int                ADDR_W     = 32,
  parameter int                LEN_W      = 13,
  parameter int                PTR_W      = 8,
  parameter int                WRD_W      = 8,
  parameter int                WORD_BYTES = 16,
  parameter logic [ADDR_W-1:0] RING_BASE  = 32'hC800_0020,
  parameter logic [ADDR_W-1:0] STAT_DST   = 32'hC800_0010,
  parameter logic [ADDR_W-1:0] STAT_SRC   = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] FIFO_SRC   = 32'h0000_2000
) (
  input  rb_desc_pkg::desc_kind_e kind,
  input  logic [PTR_W-1:0]        bat_ptr,
  input  logic [WRD_W-1:0]        bat_head,
  input  logic [WRD_W-1:0]        bat_tail,
  output logic [ADDR_W-1:0]       desc_src,
  output logic [ADDR_W-1:0]       desc_dst,
  output logic [LEN_W-1:0]        desc_len
);
  import rb_desc_pkg::*;

  localparam int WORD_SH = $clog2(WORD_BYTES);

  always_comb begin
    desc_src = '0;
    desc_dst = '0;
    desc_len = '0;
    unique case (kind)
      K_STAT: begin
        desc_src = STAT_SRC;
        desc_dst = STAT_DST;
        desc_len = LEN_W'(WORD_BYTES);
      end
      K_DATA: begin
        desc_src = FIFO_SRC;
        desc_dst = RING_BASE + (ADDR_W'(bat_ptr) << WORD_SH);
        desc_len = LEN_W'(bat_head) << WORD_SH;
      end
      K_WRAP: begin
        desc_src = FIFO_SRC;
        desc_dst = RING_BASE;
        desc_len = LEN_W'(bat_tail) << WORD_SH;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rb_desc_gen.sv
module rb_desc_gen #(
  parameter int                ADDR_W     = 32,
  parameter int                LVL_W      = 9,
  parameter int                CNT_W      = 32,
  parameter int                RING_WORDS = 254,
  parameter int                WORD_BYTES = 16,
  parameter int                MAX_XFER   = 4096,
  parameter logic [ADDR_W-1:0] RING_BASE  = 32'hC800_0020,
  parameter logic [ADDR_W-1:0] STAT_DST   = 32'hC800_0010,
  parameter logic [ADDR_W-1:0] STAT_SRC   = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] FIFO_SRC   = 32'h0000_2000,
  localparam int               LEN_W      = $clog2(MAX_XFER + 1),
  localparam int               PTR_W      = $clog2(RING_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              desc_ready,
  output logic              desc_valid,
  output logic [ADDR_W-1:0] desc_src,
  output logic [ADDR_W-1:0] desc_dst,
  output logic [LEN_W-1:0]  desc_len,
  output logic [CNT_W-1:0]  stat_count,
  output logic [PTR_W-1:0]  stat_ptr
);
  import rb_desc_pkg::*;

  localparam int WRD_W = $clog2(RING_WORDS + 1);

  // Named internal events, also observed by the bound checker.
  desc_kind_e       kind;
  logic             ev_batch_start;
  logic             ev_issue;
  logic [WRD_W-1:0] total, head, tail;
  logic [PTR_W-1:0] cur_ptr, nxt_ptr, bat_ptr;
  logic [WRD_W-1:0] bat_head, bat_tail;

  rb_batch_split #(
    .LVL_W(LVL_W), .PTR_W(PTR_W), .WRD_W(WRD_W), .RING_WORDS(RING_WORDS)
  ) u_split (
    .fifo_level(fifo_level), .cur_ptr(cur_ptr),
    .total(total), .head(head), .tail(tail), .nxt_ptr(nxt_ptr)
  );

  rb_desc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .level_nz(fifo_level != '0), .desc_ready(desc_ready),
    .has_tail(bat_tail != '0),
    .kind(kind), .desc_valid(desc_valid),
    .ev_batch_start(ev_batch_start), .ev_issue(ev_issue)
  );

  rb_ring_state #(
    .PTR_W(PTR_W), .WRD_W(WRD_W), .CNT_W(CNT_W)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .ev_batch_start(ev_batch_start),
    .total(total), .head(head), .tail(tail), .nxt_ptr(nxt_ptr),
    .cur_ptr(cur_ptr), .word_count(stat_count),
    .bat_ptr(bat_ptr), .bat_head(bat_head), .bat_tail(bat_tail)
  );

  rb_desc_fields #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PTR_W(PTR_W), .WRD_W(WRD_W),
    .WORD_BYTES(WORD_BYTES), .RING_BASE(RING_BASE), .STAT_DST(STAT_DST),
    .STAT_SRC(STAT_SRC), .FIFO_SRC(FIFO_SRC)
  ) u_fields (
    .kind(kind), .bat_ptr(bat_ptr), .bat_head(bat_head), .bat_tail(bat_tail),
    .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len)
  );

  assign stat_ptr = cur_ptr;

endmodule

// File: rtl/rb_desc_gen_chk.sv
module rb_desc_gen_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                LVL_W      = 9,
  parameter int                LEN_W      = 13,
  parameter int                PTR_W      = 8,
  parameter int                WRD_W      = 8,
  parameter int                RING_WORDS = 254,
  parameter int                WORD_BYTES = 16,
  parameter int                MAX_XFER   = 4096,
  parameter logic [ADDR_W-1:0] RING_BASE  = 32'hC800_0020,
  parameter logic [ADDR_W-1:0] STAT_DST   = 32'hC800_0010
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              desc_ready,
  input logic              desc_valid,
  input logic [ADDR_W-1:0] desc_src,
  input logic [ADDR_W-1:0] desc_dst,
  input logic [LEN_W-1:0]  desc_len,
  input logic [PTR_W-1:0]  stat_ptr,
  input logic [1:0]        kind,
  input logic              ev_batch_start,
  input logic              ev_issue,
  input logic [WRD_W-1:0]  bat_head,
  input logic [WRD_W-1:0]  bat_tail
);
  localparam int WORD_SH = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] RING_END =
    RING_BASE + ADDR_W'(RING_WORDS * WORD_BYTES);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!desc_valid && stat_ptr == '0));

  assert_zero_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd0 && fifo_level == '0) |=> !desc_valid);

  assert_stat_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_batch_start |=> (desc_valid && desc_dst == STAT_DST
                        && desc_len == LEN_W'(WORD_BYTES)));

  assert_data_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_issue && kind == 2'd1) |=> (desc_valid && kind == 2'd2));

  assert_wrap_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_issue && kind == 2'd2 && bat_tail != '0)
      |=> (desc_valid && desc_dst == RING_BASE));

  assert_total_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (32'(bat_head) + 32'(bat_tail) <= 32'(RING_WORDS)));

  assert_in_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && kind != 2'd1)
      |-> (desc_dst >= RING_BASE && desc_dst + ADDR_W'(desc_len) <= RING_END));

  assert_len_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_len != '0 && desc_len <= LEN_W'(MAX_XFER)
                    && desc_len[WORD_SH-1:0] == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_src)
                                     && $stable(desc_dst) && $stable(desc_len)));

  assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ptr < PTR_W'(RING_WORDS));

  assert_gap_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_issue && kind == 2'd3) |=> !desc_valid);

endmodule

bind rb_desc_gen rb_desc_gen_chk #(
  .ADDR_W(ADDR_W), .LVL_W(LVL_W), .LEN_W(LEN_W), .PTR_W(PTR_W),
  .WRD_W(WRD_W), .RING_WORDS(RING_WORDS), .WORD_BYTES(WORD_BYTES),
  .MAX_XFER(MAX_XFER), .RING_BASE(RING_BASE), .STAT_DST(STAT_DST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .desc_ready(desc_ready),
  .desc_valid(desc_valid), .desc_src(desc_src), .desc_dst(desc_dst),
  .desc_len(desc_len), .stat_ptr(stat_ptr), .kind(kind),
  .ev_batch_start(ev_batch_start), .ev_issue(ev_issue),
  .bat_head(bat_head), .bat_tail(bat_tail)
);

// File: tb/sim_rb_desc_gen.sv
module sim_rb_desc_gen;

  localparam int          RING   = 254;
  localparam logic [31:0] BASE   = 32'hC800_0020;
  localparam logic [31:0] SDST   = 32'hC800_0010;
  localparam logic [31:0] SSRC   = 32'h0000_1000;
  localparam logic [31:0] FSRC   = 32'h0000_2000;
  localparam logic [31:0] LIMIT  = 32'hC800_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  fifo_level = '0;
  logic        desc_ready = 1'b1;
  logic        desc_valid;
  logic [31:0] desc_src, desc_dst;
  logic [12:0] desc_len;
  logic [31:0] stat_count;
  logic [7:0]  stat_ptr;

  rb_desc_gen u0 (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .desc_ready(desc_ready),
    .desc_valid(desc_valid), .desc_src(desc_src), .desc_dst(desc_dst),
    .desc_len(desc_len), .stat_count(stat_count), .stat_ptr(stat_ptr)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int ready_mode = 0;
  int rcnt = 0;

  // Descriptors handed over, captured at the handshake edge.
  logic [31:0] got_src [0:7];
  logic [31:0] got_dst [0:7];
  logic [12:0] got_len [0:7];
  int          ndesc = 0;
  int          hold_seen = 0;
  int          hold_bad = 0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_src, prev_dst;
  logic [12:0] prev_len;

  // Model of the status record.
  int m_ptr = 0;
  int m_cnt = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (prev_wait) begin
        hold_seen = hold_seen + 1;
        if (!desc_valid || desc_src != prev_src || desc_dst != prev_dst
            || desc_len != prev_len)
          hold_bad = hold_bad + 1;
      end
      prev_wait = desc_valid && !desc_ready;
      prev_src = desc_src;
      prev_dst = desc_dst;
      prev_len = desc_len;
      if (desc_valid && desc_ready && ndesc < 8) begin
        got_src[ndesc] = desc_src;
        got_dst[ndesc] = desc_dst;
        got_len[ndesc] = desc_len;
        ndesc = ndesc + 1;
      end
    end
  end

  always @(negedge clk) begin
    rcnt <= rcnt + 1;
    desc_ready <= (ready_mode == 0) ? 1'b1 : ((rcnt % 3) == 0);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic test_reset();
    check(desc_valid == 1'b0, "R1", "valid after reset", desc_valid, 0);
    check(stat_ptr == 8'd0, "R1", "ptr after reset", stat_ptr, 0);
    check(stat_count == 32'd0, "R1", "count after reset", stat_count, 0);
  endtask

  // One batch request of n words; checks every descriptor and the record.
  task automatic run_batch(input int n, input int mode);
    int total, room, first, rest, expn, waitc, start;
    ready_mode = mode;
    start = m_ptr;
    total = (n > RING) ? RING : n;
    room  = RING - start;
    first = (total < room) ? total : room;
    rest  = total - first;
    expn  = (total == 0) ? 0 : ((rest != 0) ? 3 : 2);
    @(negedge clk);
    ndesc = 0;
    fifo_level = 9'(n);
    @(negedge clk);
    fifo_level = '0;
    if (total != 0) begin
      // R9: the status record already shows the new values
      check(stat_ptr == 8'((start + total) % RING), "R9", "ptr at batch start",
            stat_ptr, (start + total) % RING);
      check(stat_count == 32'(m_cnt + total), "R9", "count at batch start",
            stat_count, m_cnt + total);
    end
    waitc = 0;
    while (ndesc < expn && waitc < 3000) begin
      @(negedge clk);
      waitc++;
    end
    repeat (6) @(negedge clk);
    check(ndesc == expn, (rest != 0) ? "R5" : "R2", "descriptor count", ndesc, expn);
    check(desc_valid == 1'b0, "R10", "idle after batch", desc_valid, 0);
    if (expn >= 2) begin
      check(got_src[0] == SSRC && got_dst[0] == SDST, "R3", "status addr",
            got_dst[0], SDST);
      check(got_len[0] == 13'd16, "R3", "status len", got_len[0], 16);
      check(got_src[1] == FSRC, "R4", "data src", got_src[1], FSRC);
      check(got_dst[1] == BASE + 32'(start * 16), "R4", "data dst",
            got_dst[1], BASE + 32'(start * 16));
      check(got_len[1] == 13'(first * 16), "R4", "data len", got_len[1], first * 16);
      check(32'(got_dst[1]) + 32'(got_len[1]) <= LIMIT, "R7", "data end",
            32'(got_dst[1]) + 32'(got_len[1]), LIMIT);
    end
    if (expn == 3) begin
      check(got_src[2] == FSRC && got_dst[2] == BASE, "R5", "wrap dst",
            got_dst[2], BASE);
      check(got_len[2] == 13'(rest * 16), "R5", "wrap len", got_len[2], rest * 16);
      check(32'(got_len[1]) + 32'(got_len[2]) <= 32'(RING * 16), "R6",
            "batch bytes", 32'(got_len[1]) + 32'(got_len[2]), RING * 16);
    end
    m_ptr = (start + total) % RING;
    m_cnt = m_cnt + total;
    check(stat_ptr == 8'(m_ptr), "R9", "ptr after batch", stat_ptr, m_ptr);
    check(stat_count == 32'(m_cnt), "R9", "count after batch", stat_count, m_cnt);
  endtask

  task automatic test_hold();
    check(hold_seen > 0, "R8", "stall cycles observed", hold_seen, 1);
    check(hold_bad == 0, "R8", "fields held while stalled", hold_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    run_batch(5, 0);     // small batch from index 0
    run_batch(300, 0);   // R6 clamp to 254, wraps from index 5
    run_batch(249, 0);   // ends exactly on the last slot, no wrap
    run_batch(0, 0);     // R2 nothing happens
    run_batch(254, 1);   // full ring from index 0, stalled handshake
    run_batch(1, 1);
    run_batch(200, 1);
    run_batch(100, 1);   // wraps under stalls
    test_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    failures = failures + 1;
    $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule